// File: doc/BRIEF.md
# Cartridge ROM Bank Select Controller

This block selects which bank of a large banked ROM a cartridge presents to a 6502-style home computer. It keeps two separate 8-bit bank numbers. One serves the upper ROM window. The other serves the lower expansion windows. Each number drives the high ROM address lines of its window. The drive is enabled only while the processor accesses that window through its memory-block select.

Software changes a bank by storing a byte to one of two addresses in the I/O select region. The store counts only when phase 2 goes high and then low again while the I/O select is active and R/W shows a write. A decoded strobe on its own never loads a register.

While system reset is asserted, both registers are held at bank 0. Anything on the data bus during reset is ignored, even over a reset pulse that lasts seconds. The menu in bank 0 is therefore always the first thing the processor sees.

Top module: `cart_bank_ctrl`

## Requirements
- R1: While rst_ni is low, both bank registers read 0. After rst_ni rises they still read 0 until the first qualified write.
- R2: No bus activity while rst_ni is low changes a register, including complete phase-2 write cycles to the register addresses.
- R3: The upper register loads data_i on a write cycle that meets all of these conditions: io_sel_ni is 0, rw_i is 0 and addr_i is 16'h9FFF during the phase-2 high phase, and phi2_i then goes low. The register takes the data sampled in the last clock cycle of that high phase. The new value appears on the clock edge at which phi2_i is first sampled low.
- R4: The lower register loads in the same way from a write cycle to 16'h9FFE.
- R5: A write cycle to any other address, even with io_sel_ni at 0, leaves both registers unchanged.
- R6: A write cycle to a register address with io_sel_ni at 1 leaves both registers unchanged.
- R7: A read cycle (rw_i = 1) to a register address leaves both registers unchanged.
- R8: A decoded write with no phase-2 high-then-low transition leaves both registers unchanged.
- R9: hi_oe_o is 1 exactly when blk_hi_ni is 0. hi_bank_o carries the upper register while hi_oe_o is 1 and reads 0 otherwise.
- R10: lo_oe_o is 1 exactly when any bit of blk_lo_ni is 0. lo_bank_o carries the lower register while lo_oe_o is 1 and reads 0 otherwise.
- R11: A load of either register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, faster than phase 2 |
| rst_ni | input | 1 | System reset, active low, asynchronous |
| phi2_i | input | 1 | Processor phase-2 clock |
| rw_i | input | 1 | 1 = read, 0 = write |
| io_sel_ni | input | 1 | I/O region select, active low |
| addr_i | input | 16 | Processor address |
| data_i | input | 8 | Processor data bus |
| blk_hi_ni | input | 1 | Upper ROM window select, active low |
| blk_lo_ni | input | 3 | Lower window selects, active low |
| hi_bank_o | output | 8 | Upper window bank address |
| hi_oe_o | output | 1 | Upper bank address drive enable |
| lo_bank_o | output | 8 | Lower window bank address |
| lo_oe_o | output | 1 | Lower bank address drive enable |

## Verification
The hardest state to create is garbage captured during reset. To create it, the bench runs complete, correctly formed phase-2 write cycles to both register addresses while reset is held low, with the data bus changing on every cycle. It then checks that bank 0 appears once reset is released. Loads are swept over all 256 values in each window. Near-miss cycles change one qualifier at a time: wrong address, I/O select inactive, read instead of write, and no phase-2 pulse. All 16 combinations of the window selects are applied as well.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  localparam int unsigned NUM_WIN = 2;
  typedef enum logic [0:0] {
    WIN_HI = 1'b0,
    WIN_LO = 1'b1
  } win_e;
endpackage

// File: rtl/cart_bus_strobe.sv
module cart_bus_strobe #(
  parameter int unsigned NUM_WIN = 2,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_ADDR = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               phi2_i,
  input  logic               rw_i,
  input  logic               io_sel_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [NUM_WIN-1:0] wr_o,
  output logic [DATA_W-1:0]  wr_data_o
);
  logic               phi2_q;
  logic [NUM_WIN-1:0] pend_hit_q;
  logic [DATA_W-1:0]  pend_data_q;
  logic               phi2_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phi2_q <= 1'b0;
    else         phi2_q <= phi2_i;
  end

  // latch qualifiers during phase 2 high; commit on its falling edge
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_hit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pend_hit_q[w] <= 1'b0;
      else if (phi2_i) pend_hit_q[w] <= !io_sel_ni && !rw_i && (addr_i == WIN_ADDR[w]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_data_q <= '0;
    else if (phi2_i) pend_data_q <= data_i;
  end

  assign phi2_fall = phi2_q && !phi2_i;
  assign wr_o      = phi2_fall ? pend_hit_q : '0;
  assign wr_data_o = pend_data_q;

  a_r8_wr_on_phi2_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_o) |-> ($past(phi2_i) && !phi2_i));
  a_r11_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_o));
endmodule

// File: rtl/cart_bank_reg.sv
module cart_bank_reg #(
  parameter int unsigned BANK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BANK_W-1:0] data_i,
  output logic [BANK_W-1:0] bank_o
);
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bank_q <= '0;
    else if (wr_i) bank_q <= data_i;
  end

  assign bank_o = bank_q;

  a_r1_zero_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (bank_q == '0));
  a_r5_change_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank_q) |-> $past(wr_i));
endmodule

// File: rtl/cart_win_drive.sv
module cart_win_drive #(
  parameter int unsigned BANK_W = 8,
  parameter int unsigned NSEL   = 1
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [NSEL-1:0]   sel_ni,
  output logic [BANK_W-1:0] bank_o,
  output logic              oe_o
);
  // tri-state modelled as enable plus zeroed data
  assign oe_o   = ~&sel_ni;
  assign bank_o = oe_o ? bank_i : '0;
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned BANK_W  = 8,
  parameter int unsigned LO_BLKS = 3,
  parameter logic [ADDR_W-1:0] HI_ADDR = 16'h9FFF,
  parameter logic [ADDR_W-1:0] LO_ADDR = 16'h9FFE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               phi2_i,
  input  logic               rw_i,
  input  logic               io_sel_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BANK_W-1:0]  data_i,
  input  logic               blk_hi_ni,
  input  logic [LO_BLKS-1:0] blk_lo_ni,
  output logic [BANK_W-1:0]  hi_bank_o,
  output logic               hi_oe_o,
  output logic [BANK_W-1:0]  lo_bank_o,
  output logic               lo_oe_o
);
  import cart_bank_pkg::*;

  localparam logic [NUM_WIN-1:0][ADDR_W-1:0] WinAddr = {LO_ADDR, HI_ADDR};

  logic [NUM_WIN-1:0] wr;
  logic [BANK_W-1:0]  wr_data;
  logic [BANK_W-1:0]  bank [NUM_WIN];

  cart_bus_strobe #(
    .NUM_WIN (NUM_WIN),
    .ADDR_W  (ADDR_W),
    .DATA_W  (BANK_W),
    .WIN_ADDR(WinAddr)
  ) u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phi2_i   (phi2_i),
    .rw_i     (rw_i),
    .io_sel_ni(io_sel_ni),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .wr_o     (wr),
    .wr_data_o(wr_data)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_reg
    cart_bank_reg #(.BANK_W(BANK_W)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wr_i  (wr[w]),
      .data_i(wr_data),
      .bank_o(bank[w])
    );
  end

  cart_win_drive #(.BANK_W(BANK_W), .NSEL(1)) u_drv_hi (
    .bank_i(bank[WIN_HI]),
    .sel_ni(blk_hi_ni),
    .bank_o(hi_bank_o),
    .oe_o  (hi_oe_o)
  );

  cart_win_drive #(.BANK_W(BANK_W), .NSEL(LO_BLKS)) u_drv_lo (
    .bank_i(bank[WIN_LO]),
    .sel_ni(blk_lo_ni),
    .bank_o(lo_bank_o),
    .oe_o  (lo_oe_o)
  );

  a_r9_hi_oe_own_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_oe_o |-> !blk_hi_ni);
  a_r9_hi_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_oe_o |-> (hi_bank_o == '0));
  a_r10_lo_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&blk_lo_ni) |-> (!lo_oe_o && lo_bank_o == '0));
  a_r7_read_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(phi2_i) && $past(rw_i) && !phi2_i) |-> (wr == '0));
endmodule

// File: tb/cart_bank_ctrl_test.sv
module cart_bank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        phi2 = 1'b0;
  logic        rw = 1'b1;
  logic        io_n = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  data = 8'h00;
  logic        blk_hi_n = 1'b1;
  logic [2:0]  blk_lo_n = 3'b111;
  logic [7:0]  hi_bank, lo_bank;
  logic        hi_oe, lo_oe;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  cart_bank_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .phi2_i(phi2), .rw_i(rw), .io_sel_ni(io_n),
    .addr_i(addr), .data_i(data), .blk_hi_ni(blk_hi_n), .blk_lo_ni(blk_lo_n),
    .hi_bank_o(hi_bank), .hi_oe_o(hi_oe), .lo_bank_o(lo_bank), .lo_oe_o(lo_oe)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // one processor bus cycle; pulse selects whether phase 2 goes high
  task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d,
                           input logic r, input logic io, input bit pulse);
    @(negedge clk);
    addr = a; data = d; rw = r; io_n = io;
    @(negedge clk);
    if (pulse) phi2 = 1'b1;
    @(negedge clk);
    @(negedge clk);
    phi2 = 1'b0;
    @(negedge clk);
    io_n = 1'b1; rw = 1'b1; data = ~d;
    @(negedge clk);
  endtask

  task automatic read_banks(output logic [7:0] h, output logic [7:0] l);
    blk_hi_n = 1'b0; blk_lo_n = 3'b110;
    @(negedge clk);
    h = hi_bank; l = lo_bank;
    blk_hi_n = 1'b1; blk_lo_n = 3'b111;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] h, l, exp_h, exp_l;
    // R2: full write cycles during reset with changing data
    for (int i = 0; i < 20; i++) begin
      bus_cycle((i % 2) ? 16'h9FFF : 16'h9FFE, 8'(i * 37 + 5), 1'b0, 1'b0, 1'b1);
      blk_hi_n = 1'b0; blk_lo_n = 3'b011;
      @(negedge clk);
      if (i % 5 == 0) begin
        check("R1 hi in reset", hi_bank, 0);
        check("R1 lo in reset", lo_bank, 0);
      end
      blk_hi_n = 1'b1; blk_lo_n = 3'b111;
    end
    @(negedge clk); rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    read_banks(h, l);
    check("R2 hi after reset", h, 0);
    check("R2 lo after reset", l, 0);

    // R3/R11: sweep upper register
    exp_l = 8'h00;
    for (int v = 0; v < 256; v++) begin
      bus_cycle(16'h9FFF, 8'(v), 1'b0, 1'b0, 1'b1);
      read_banks(h, l);
      check("R3 hi load", h, v);
      check("R11 lo kept", l, exp_l);
    end
    exp_h = 8'hFF;
    // R4/R11: sweep lower register
    for (int v = 0; v < 256; v++) begin
      bus_cycle(16'h9FFE, 8'(255 - v), 1'b0, 1'b0, 1'b1);
      read_banks(h, l);
      check("R4 lo load", l, 255 - v);
      check("R11 hi kept", h, exp_h);
    end
    exp_l = 8'h00;
    bus_cycle(16'h9FFF, 8'h5A, 1'b0, 1'b0, 1'b1); exp_h = 8'h5A;
    bus_cycle(16'h9FFE, 8'hC3, 1'b0, 1'b0, 1'b1); exp_l = 8'hC3;

    // R5: other addresses in and around the region
    for (int k = 0; k < 6; k++) begin
      logic [15:0] a;
      case (k)
        0: a = 16'h9FFD; 1: a = 16'h9C00; 2: a = 16'h9FFC;
        3: a = 16'h1FFF; 4: a = 16'hBFFF; default: a = 16'h9EFF;
      endcase
      bus_cycle(a, 8'h11, 1'b0, 1'b0, 1'b1);
      read_banks(h, l);
      check("R5 hi unchanged", h, exp_h);
      check("R5 lo unchanged", l, exp_l);
    end
    // R6: select inactive
    bus_cycle(16'h9FFF, 8'h22, 1'b0, 1'b1, 1'b1);
    bus_cycle(16'h9FFE, 8'h22, 1'b0, 1'b1, 1'b1);
    read_banks(h, l);
    check("R6 hi unchanged", h, exp_h);
    check("R6 lo unchanged", l, exp_l);
    // R7: reads
    bus_cycle(16'h9FFF, 8'h33, 1'b1, 1'b0, 1'b1);
    bus_cycle(16'h9FFE, 8'h33, 1'b1, 1'b0, 1'b1);
    read_banks(h, l);
    check("R7 hi unchanged", h, exp_h);
    check("R7 lo unchanged", l, exp_l);
    // R8: decoded write without phase 2
    bus_cycle(16'h9FFF, 8'h44, 1'b0, 1'b0, 1'b0);
    bus_cycle(16'h9FFE, 8'h44, 1'b0, 1'b0, 1'b0);
    read_banks(h, l);
    check("R8 hi unchanged", h, exp_h);
    check("R8 lo unchanged", l, exp_l);

    // R3 timing: value appears on the edge where phi2 is first seen low
    @(negedge clk); addr = 16'h9FFF; data = 8'h77; rw = 1'b0; io_n = 1'b0;
    blk_hi_n = 1'b0;
    @(negedge clk); phi2 = 1'b1;
    @(negedge clk);
    check("R3 not before fall", hi_bank, exp_h);
    phi2 = 1'b0;
    @(negedge clk);
    check("R3 after fall edge", hi_bank, 8'h77);
    io_n = 1'b1; rw = 1'b1; blk_hi_n = 1'b1; exp_h = 8'h77;

    // R9/R10: all select combinations
    for (int s = 0; s < 16; s++) begin
      blk_hi_n = s[3]; blk_lo_n = 3'(s);
      @(negedge clk);
      check("R9 hi oe", hi_oe, !s[3]);
      check("R9 hi bank", hi_bank, s[3] ? 0 : exp_h);
      check("R10 lo oe", lo_oe, (3'(s) != 3'b111));
      check("R10 lo bank", lo_bank, (3'(s) != 3'b111) ? exp_l : 0);
    end
    blk_hi_n = 1'b1; blk_lo_n = 3'b111;

    // R1: reset again clears both
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    read_banks(h, l);
    check("R1 hi cleared", h, 0);
    check("R1 lo cleared", l, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule